// File: doc/BRIEF.md
# Two-Port Shared Memory Arbiter

This block lets two processors share one single-port byte store that either of them may address at any time. Each side drives a request together with an address, a write enable and write data. The block returns a ready flag and read data to each side. A side whose ready is low is in a wait state and must hold its request until ready goes high.

The first side to ask gets the store at once. The other side is held off. The side that owns the store keeps it across back-to-back accesses, up to a parameterised run length, while the other side is waiting. This means a read-modify-write completes without interruption. When no side owned the store in the previous cycle and both ask in the same cycle, port 0 wins. Software on the two sides can exchange messages through a small mailbox at low addresses. The hardware does not enforce that convention.

Top module: `shmem_window`

## Requirements
- R1: After reset, while neither side requests, both ready outputs are low.
- R2: A request from one side while the other side is not requesting gets ready high in the same cycle.
- R3: The two ready outputs are never high together, and a ready is high only while its own request is high.
- R4: When both sides request in the same cycle and neither side was granted in the previous cycle, port 0 gets ready and port 1 waits.
- R5: A side granted in the previous cycle keeps the grant while its request stays high and it has held fewer than RUN_MAX consecutive grants. This holds even if the other side is waiting. A waiting side therefore gets the store in the cycle after the owner drops its request.
- R6: A side that has waited RUN_MAX consecutive cycles with its request high is granted in the next cycle. With RUN_MAX = 2, once two consecutive grants have gone to one side, the waiting side is granted in the following cycle.
- R7: A write (write enable high) updates the byte at its address at the clock edge that ends its ready cycle. A read returns the stored byte on that side's read data during its ready cycle.
- R8: A side that requests alone keeps ready high on every cycle of an unbroken run of any length.
- R9: Both sides see one common store. A mailbox written by one side is read back unchanged by the other. The mailbox layout is a flag byte at address 0, a two-byte message start at addresses 1 and 2, and a two-byte message length at addresses 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| p0_req | input | 1 | Port 0 access request |
| p0_we | input | 1 | Port 0 write enable |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_rdata | output | DATA_W | Port 0 read data, valid while p0_ready |
| p0_ready | output | 1 | Port 0 granted this cycle |
| p1_req | input | 1 | Port 1 access request |
| p1_we | input | 1 | Port 1 write enable |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_rdata | output | DATA_W | Port 1 read data, valid while p1_ready |
| p1_ready | output | 1 | Port 1 granted this cycle |

## Verification
The bench uses the default parameters: a 512-byte store with 9-bit addresses and RUN_MAX = 2. With RUN_MAX = 2, the run limit is reached after only two consecutive grants. The bench can therefore drive a full handover in both directions within a few cycles, and confirm that ownership alternates in pairs while both sides hold their requests. The mailbox bytes sit at the bottom of the window, so cross-port visibility is checked with five addresses.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_P0   = 2'd1,
    OWN_P1   = 2'd2
  } owner_e;

  // Grant decision for one cycle.
  // prev: side granted in the previous cycle; at_limit: that side has used its run.
  function automatic owner_e pick_grant(input logic r0, input logic r1,
                                        input owner_e prev, input logic at_limit);
    owner_e g;
    g = OWN_NONE;
    if (prev == OWN_P0 && r0 && (!r1 || !at_limit))      g = OWN_P0;
    else if (prev == OWN_P1 && r1 && (!r0 || !at_limit)) g = OWN_P1;
    else if (r0 && r1)                                   g = (prev == OWN_P0) ? OWN_P1 : OWN_P0;
    else if (r0)                                         g = OWN_P0;
    else if (r1)                                         g = OWN_P1;
    return g;
  endfunction

  // Saturating run counter step.
  function automatic int unsigned next_run(input logic same, input logic any,
                                           input int unsigned cur, input int unsigned lim);
    if (!any)  return 0;
    if (!same) return 1;
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/shmem_arb_core.sv
module shmem_arb_core
  import shmem_pkg::*;
#(
  parameter int RUN_MAX = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req0_i,
  input  logic req1_i,
  output logic gnt0_o,
  output logic gnt1_o
);
  localparam int RUN_W  = $clog2(RUN_MAX + 1);
  localparam int WAIT_W = $clog2(RUN_MAX + 2);

  owner_e             prev_q;
  owner_e             gnt_now;
  logic [RUN_W-1:0]   run_q;
  logic               at_limit;
  logic               same_side;

  assign at_limit  = (int'(run_q) >= RUN_MAX);
  assign gnt_now   = pick_grant(req0_i, req1_i, prev_q, at_limit);
  assign same_side = (gnt_now != OWN_NONE) && (gnt_now == prev_q);
  assign gnt0_o    = (gnt_now == OWN_P0);
  assign gnt1_o    = (gnt_now == OWN_P1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= OWN_NONE;
      run_q  <= '0;
    end else begin
      prev_q <= gnt_now;
      run_q  <= RUN_W'(next_run(same_side, gnt_now != OWN_NONE, int'(run_q), RUN_MAX));
    end
  end

  // Waiting-time counters, observation only.
  logic [WAIT_W-1:0] wait0_q, wait1_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait0_q <= '0;
      wait1_q <= '0;
    end else begin
      wait0_q <= (req0_i && !gnt0_o && int'(wait0_q) <= RUN_MAX) ? wait0_q + 1'b1 : '0;
      wait1_q <= (req1_i && !gnt1_o && int'(wait1_q) <= RUN_MAX) ? wait1_q + 1'b1 : '0;
    end
  end

  // R2
  lone_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_i && !req1_i) |-> gnt0_o);
  // R2
  lone_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req1_i && !req0_i) |-> gnt1_o);
  // R3
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt0_o, gnt1_o}) && (!gnt0_o || req0_i) && (!gnt1_o || req1_i));
  // R4
  tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q == OWN_NONE && req0_i && req1_i) |-> gnt0_o);
  // R6
  bound0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_i && int'(wait0_q) >= RUN_MAX) |-> gnt0_o);
  // R6
  bound1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req1_i && int'(wait1_q) >= RUN_MAX) |-> gnt1_o);
endmodule

// File: rtl/shmem_arb_ram.sv
module shmem_arb_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt0_i,
  input  logic              gnt1_i,
  input  logic              we0_i,
  input  logic              we1_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic [DATA_W-1:0] wdata0_i,
  input  logic [DATA_W-1:0] wdata1_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] addr_sel;
  logic [DATA_W-1:0] wdata_sel;
  logic              wr_en;

  // Single port: the granted side drives address and data.
  assign addr_sel  = gnt1_i ? addr1_i  : addr0_i;
  assign wdata_sel = gnt1_i ? wdata1_i : wdata0_i;
  assign wr_en     = (gnt0_i && we0_i) || (gnt1_i && we1_i);
  assign rdata_o   = mem_q[addr_sel];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr_sel] <= wdata_sel;
  end

  // R7
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(addr_sel)] == $past(wdata_sel)));
endmodule

// File: rtl/shmem_window.sv
module shmem_window #(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int RUN_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic [DATA_W-1:0] p0_rdata,
  output logic              p0_ready,
  input  logic              p1_req,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic [DATA_W-1:0] p1_rdata,
  output logic              p1_ready
);
  logic              gnt0, gnt1;
  logic [DATA_W-1:0] rd_shared;

  shmem_arb_core #(.RUN_MAX(RUN_MAX)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .req0_i (p0_req),
    .req1_i (p1_req),
    .gnt0_o (gnt0),
    .gnt1_o (gnt1)
  );

  shmem_arb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt0_i   (gnt0),
    .gnt1_i   (gnt1),
    .we0_i    (p0_we),
    .we1_i    (p1_we),
    .addr0_i  (p0_addr),
    .addr1_i  (p1_addr),
    .wdata0_i (p0_wdata),
    .wdata1_i (p1_wdata),
    .rdata_o  (rd_shared)
  );

  assign p0_ready = gnt0;
  assign p1_ready = gnt1;
  assign p0_rdata = rd_shared;
  assign p1_rdata = rd_shared;

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p0_req && !p1_req) |-> (!p0_ready && !p1_ready));
  // R8
  solo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p0_ready) && p0_req && !p1_req) |-> p0_ready);
endmodule

// File: tb/shmem_window_tb.sv
module shmem_window_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0_req = 0, p0_we = 0, p1_req = 0, p1_we = 0;
  logic [8:0] p0_addr = '0, p1_addr = '0;
  logic [7:0] p0_wdata = '0, p1_wdata = '0;
  logic [7:0] p0_rdata, p1_rdata;
  logic p0_ready, p1_ready;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shmem_window u_dut (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
    .p0_rdata(p0_rdata), .p0_ready(p0_ready),
    .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p1_rdata(p1_rdata), .p1_ready(p1_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let combinational paths settle, then check.
  task automatic drive(input bit r0, input bit w0, input int a0, input int d0,
                       input bit r1, input bit w1, input int a1, input int d1);
    @(negedge clk);
    p0_req = r0; p0_we = w0; p0_addr = 9'(a0); p0_wdata = 8'(d0);
    p1_req = r1; p1_we = w1; p1_addr = 9'(a1); p1_wdata = 8'(d1);
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_gnt(input bit e0, input bit e1, input string req);
    check(p0_ready == e0, req, p0_ready, e0);
    check(p1_ready == e1, req, p1_ready, e1);
  endtask

  task automatic t_reset();
    idle();
    expect_gnt(0, 0, "R1 idle");
  endtask

  task automatic t_write_read();
    drive(1, 1, 5, 8'hA5, 0, 0, 0, 0);
    expect_gnt(1, 0, "R2 lone write");
    drive(1, 0, 5, 0, 0, 0, 0, 0);
    check(p0_rdata == 8'hA5, "R7 read back", p0_rdata, 8'hA5);
    drive(0, 0, 0, 0, 1, 0, 5, 0);
    expect_gnt(0, 1, "R2 lone p1");
    check(p1_rdata == 8'hA5, "R7 p1 read", p1_rdata, 8'hA5);
    idle();
  endtask

  task automatic t_tie();
    idle();
    drive(1, 1, 7, 8'h11, 1, 1, 7, 8'h22);
    expect_gnt(1, 0, "R4 tie");
    drive(0, 0, 0, 0, 1, 1, 7, 8'h22);
    expect_gnt(0, 1, "R5 one cycle wait");
    drive(0, 0, 0, 0, 1, 0, 7, 0);
    check(p1_rdata == 8'h22, "R7 later write wins", p1_rdata, 8'h22);
    idle();
  endtask

  task automatic t_burst();
    idle();
    drive(1, 0, 1, 0, 1, 0, 2, 0);
    expect_gnt(1, 0, "R5 owner run 1");
    drive(1, 0, 1, 0, 1, 0, 2, 0);
    expect_gnt(1, 0, "R5 owner run 2");
    drive(1, 0, 1, 0, 1, 0, 2, 0);
    expect_gnt(0, 1, "R6 handover");
    drive(1, 0, 1, 0, 1, 0, 2, 0);
    expect_gnt(0, 1, "R5 p1 run 2");
    drive(1, 0, 1, 0, 1, 0, 2, 0);
    expect_gnt(1, 0, "R6 handback");
    idle();
  endtask

  task automatic t_first_come();
    idle();
    drive(0, 0, 0, 0, 1, 0, 3, 0);
    expect_gnt(0, 1, "R2 p1 first");
    drive(1, 0, 3, 0, 1, 0, 3, 0);
    expect_gnt(0, 1, "R5 p1 keeps");
    drive(1, 0, 3, 0, 1, 0, 3, 0);
    expect_gnt(1, 0, "R6 p0 in");
    idle();
  endtask

  task automatic t_solo();
    for (int i = 0; i < 6; i++) begin
      drive(0, 0, 0, 0, 1, 0, 9, 0);
      expect_gnt(0, 1, "R8 solo run");
    end
    idle();
  endtask

  task automatic t_mailbox();
    int box [5] = '{8'h01, 8'h40, 8'h01, 8'h10, 8'h00};
    for (int i = 0; i < 5; i++) drive(1, 1, i, box[i], 0, 0, 0, 0);
    idle();
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 0, 0, 1, 0, i, 0);
      check(p1_rdata == 8'(box[i]), "R9 mailbox field", p1_rdata, box[i]);
    end
    drive(0, 0, 0, 0, 1, 1, 0, 8'h02);
    idle();
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    check(p0_rdata == 8'h02, "R9 reply flag", p0_rdata, 8'h02);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_tie();
    t_burst();
    t_first_come();
    t_solo();
    t_mailbox();
    finish_run();
  end
endmodule